// File: doc/BRIEF.md
# Orderly Suspend Controller

This block lets host software pause a network controller cleanly, so that configuration can be changed without a full re-initialization. The host writes 1 to a suspend bit. From the next cycle the block raises two hold signals. One stops any new transmit or receive packet from starting. The other stops any new DMA burst from starting. Work already in flight is allowed to finish. The host then polls the suspend bit until it reads back 1.

There are two entry policies, and the fast-suspend enable input picks between them. In fast mode, acknowledgement waits only for the four activity flags to go low: transmit DMA, receive DMA, transmit on the wire and receive on the wire. Data may still be held in the buffers when suspend is acknowledged. In slow mode, acknowledgement also waits for the transmit buffer to report empty. Writing 0 to the suspend bit releases everything on the next cycle.

Top module: `suspend_ctl`

## Requirements
- R1: After reset, `hold_pkt`, `hold_dma` and `susp_rd` are all 0.
- R2: A cycle with `bit_wr`=1 and `bit_wdata`=1 makes `hold_pkt` and `hold_dma` 1 after that clock edge, while `susp_rd` is still 0 at that point.
- R3: While a suspend request is held in fast mode (`fast_en`=1), `susp_rd` becomes 1 after the first clock edge at which all four busy inputs are low.
- R4: While any one of `txdma_busy`, `rxdma_busy`, `txline_busy` or `rxline_busy` is 1, `susp_rd` does not become 1.
- R5: In slow mode (`fast_en`=0), acknowledgement additionally needs `txbuf_empty`=1 in that same cycle. In fast mode, `txbuf_empty` is ignored.
- R6: A cycle with `bit_wr`=1 and `bit_wdata`=0 makes all three outputs 0 after that edge. This takes precedence over an acknowledgement condition met in the same cycle.
- R7: Once `susp_rd` is 1, it stays 1 and the holds stay 1 while the request is held, whatever the busy and empty inputs do.
- R8: When `bit_wr`=0, `bit_wdata` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_wr | input | 1 | Host write strobe for the suspend bit |
| bit_wdata | input | 1 | Value written to the suspend bit |
| fast_en | input | 1 | 1 selects the fast policy, 0 selects the slow policy |
| txdma_busy | input | 1 | Transmit DMA transfer in progress |
| rxdma_busy | input | 1 | Receive DMA transfer in progress |
| txline_busy | input | 1 | Packet being sent on the wire |
| rxline_busy | input | 1 | Packet being received from the wire |
| txbuf_empty | input | 1 | Transmit buffer holds no data |
| hold_pkt | output | 1 | Blocks the start of new transmit or receive packets |
| hold_dma | output | 1 | Blocks the start of new DMA bursts |
| susp_rd | output | 1 | Read-back value of the suspend bit; 1 once suspended |

## Verification
Two things can land in the same cycle: a release write and a drain that has just completed. The bench provokes this by writing 0 in the very cycle in which the request is held and every busy flag is low. It then expects all outputs to be 0 after that edge, with no one-cycle acknowledge pulse. A second collision is a request write that arrives while everything is already idle. Here the read-back must still be 0 after the write edge and may rise only one edge later.

// File: rtl/suspend_ctl.sv
module suspend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_wr,
  input  logic bit_wdata,
  input  logic fast_en,
  input  logic txdma_busy,
  input  logic rxdma_busy,
  input  logic txline_busy,
  input  logic rxline_busy,
  input  logic txbuf_empty,
  output logic hold_pkt,
  output logic hold_dma,
  output logic susp_rd
);

  logic req_q, done_q;
  logic idle, drained;

  assign idle    = !(txdma_busy | rxdma_busy | txline_busy | rxline_busy);
  assign drained = idle && (fast_en || txbuf_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (bit_wr) begin
      req_q  <= bit_wdata;
      done_q <= bit_wdata && done_q;
    end else if (req_q && drained) begin
      done_q <= 1'b1;
    end
  end

  assign hold_pkt = req_q;
  assign hold_dma = req_q;
  assign susp_rd  = done_q;

  p_rd_implies_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_rd |-> (hold_pkt && hold_dma));

  p_req_raises_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && bit_wdata) |=> (hold_pkt && hold_dma));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !bit_wdata) |=> (!hold_pkt && !hold_dma && !susp_rd));

  p_ack_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_rd && (txdma_busy || rxdma_busy || txline_busy || rxline_busy)) |=> !susp_rd);

  p_slow_needs_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_rd && !fast_en && !txbuf_empty) |=> !susp_rd);

  p_ack_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pkt && !bit_wr && fast_en && !txdma_busy && !rxdma_busy && !txline_busy && !rxline_busy)
      |=> susp_rd);

endmodule

// File: tb/suspend_ctl_bench.sv
module suspend_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_wr = 1'b0, bit_wdata = 1'b0, fast_en = 1'b1;
  logic txdma_busy = 1'b0, rxdma_busy = 1'b0, txline_busy = 1'b0, rxline_busy = 1'b0;
  logic txbuf_empty = 1'b1;
  logic hold_pkt, hold_dma, susp_rd;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  suspend_ctl u_suspend_ctl (
    .clk(clk), .rst_n(rst_n), .bit_wr(bit_wr), .bit_wdata(bit_wdata), .fast_en(fast_en),
    .txdma_busy(txdma_busy), .rxdma_busy(rxdma_busy), .txline_busy(txline_busy),
    .rxline_busy(rxline_busy), .txbuf_empty(txbuf_empty),
    .hold_pkt(hold_pkt), .hold_dma(hold_dma), .susp_rd(susp_rd));

  // {wr, wdata, fast, rxline, txline, rxdma, txdma, empty, exp_hold, exp_rd}
  localparam int N = 16;
  localparam logic [9:0] VEC [N] = '{
    10'b0_1_1_0000_1_0_0, // R8 wdata without strobe
    10'b1_1_1_0001_1_1_0, // R2 request, txdma busy
    10'b0_0_1_0001_1_1_0, // R4 txdma
    10'b0_0_1_0010_1_1_0, // R4 rxdma
    10'b0_0_1_0100_1_1_0, // R4 txline
    10'b0_0_1_1000_1_1_0, // R4 rxline
    10'b0_0_1_0000_0_1_1, // R3 / R5 fast ignores empty
    10'b0_0_1_1111_0_1_1, // R7 sticky
    10'b1_0_1_0000_1_0_0, // R6 release
    10'b1_1_0_0000_0_1_0, // R2 slow request
    10'b0_0_0_0000_0_1_0, // R5 waits for empty
    10'b0_0_0_0000_1_1_1, // R5 empty seen
    10'b1_0_0_0000_1_0_0, // R6 release
    10'b1_1_1_0000_1_1_0, // R2 rd still 0 after write
    10'b1_0_1_0000_1_0_0, // R6 release beats drain
    10'b0_0_1_0000_1_0_0  // R8 stays released
  };
  localparam int TAG [N] = '{8,2,4,4,4,4,3,7,6,2,5,5,6,2,6,8};

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {hold_pkt,hold_dma,susp_rd} actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 reset", {hold_pkt, hold_dma, susp_rd}, 3'b000);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {bit_wr, bit_wdata, fast_en, rxline_busy, txline_busy, rxdma_busy, txdma_busy, txbuf_empty}
        = VEC[i][9:2];
      @(posedge clk);
      #1 check($sformatf("R%0d row %0d", TAG[i], i), {hold_pkt, hold_dma, susp_rd},
               {VEC[i][1], VEC[i][1], VEC[i][0]});
    end
    // R1: reset while suspended clears everything
    @(negedge clk);
    {bit_wr, bit_wdata} = 2'b11;
    {txdma_busy, rxdma_busy, txline_busy, rxline_busy} = 4'b0000;
    @(negedge clk) bit_wr = 1'b0;
    @(posedge clk);
    #1 check("R3 directed", {hold_pkt, hold_dma, susp_rd}, 3'b111);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    #1 check("R1 mid-run reset", {hold_pkt, hold_dma, susp_rd}, 3'b000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule